// File: doc/BRIEF.md
# Dual-Tree Wavelet Analysis Stage

This block performs one level of a one-dimensional dual-tree complex wavelet decomposition. A single stream of signed 16-bit samples drives two real filter banks side by side. Tree A produces the real part of the complex coefficients and tree B the imaginary part. The tap sets of the two trees are designed so that their delays differ by half a sample. Each tree has a 10-tap lowpass filter and a 10-tap highpass filter, and each output is decimated by two. The lowpass outputs are approximation coefficients, which a later level would decompose further. The highpass outputs are detail coefficients and are kept.

The tap values are parameters, and there are two sets of them. One set serves the first decomposition level and the other serves all deeper levels. A select line, sampled together with each input sample, chooses between them. The block keeps one shared history of the last nine accepted samples. Every second accepted sample produces one result per filter, one clock cycle later. The four results appear on four aligned output streams, so N accepted samples yield 2N coefficients in total. A synchronous clear empties the history and restarts the decimation phase.

Top module: `dtw_analysis_stage`

## Requirements
- R1: While reset is asserted and right after it, all four valid strobes are low and all four coefficient outputs read zero.
- R2: An emitted coefficient equals the sum over i = 0..9 of tap[i] times x[k-i]. Here x[k] is the current sample and x[k-1..k-9] are the previously accepted samples. Samples from before reset or before a clear count as zero.
- R3: Accepted samples are numbered from 0 after reset or clear. Results are emitted only for even-numbered samples, exactly one cycle after the sample is presented. Between emissions each coefficient output holds its last value.
- R4: The four valid strobes (lowpass A, highpass A, lowpass B, highpass B) are always asserted in the same cycle.
- R5: Each sample uses the first-level tap set when stage_later is 0 and the later-level tap set when it is 1. stage_later is sampled with that sample and has no effect on any other result.
- R6: Taps are signed with FRAC = 14 fractional bits. The full-precision sum is rounded half up to an integer (add 2^13, then shift right arithmetically by 14). The result is saturated to the range -32768 to 32767.
- R7: A cycle with clr high discards that cycle's sample, clears the history to zero, and makes the next accepted sample number 0. The cycle after a clear has no valid strobe.
- R8: Cycles with in_valid low change neither the history nor the decimation phase.
- R9: After a clear, 2N accepted samples yield exactly 4N coefficients across the four streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous flush of the history and the decimation phase |
| in_valid | input | 1 | Qualifies in_data |
| in_data | input | 16 | Signed input sample |
| stage_later | input | 1 | Selects the tap set: 0 first level, 1 later levels |
| lo_a | output | 16 | Tree A lowpass (approximation) coefficient |
| lo_a_vld | output | 1 | lo_a is valid |
| hi_a | output | 16 | Tree A highpass (detail) coefficient |
| hi_a_vld | output | 1 | hi_a is valid |
| lo_b | output | 16 | Tree B lowpass (approximation) coefficient |
| lo_b_vld | output | 1 | lo_b is valid |
| hi_b | output | 16 | Tree B highpass (detail) coefficient |
| hi_b_vld | output | 1 | hi_b is valid |

## Verification
A history entry that is stale or shifted shows up as a wrong coefficient on the very next emission. The effect lasts for up to five emissions, until the bad entry ages out of the ten-tap window. A decimation phase that has flipped shows at the port within one sample: a strobe appears after an odd-numbered sample, or fails to appear after an even one. The scoreboard catches both, because it keeps its own history and phase. A wrong tap-set choice or a rounding error changes the affected value in the same emission. Patterns with large inputs drive the all-positive tap set into both saturation limits.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
    parameter int unsigned SMP_W = 16;
    parameter int unsigned NFILT = 4;

    typedef logic signed [SMP_W-1:0] sample_t;
    typedef sample_t [NFILT-1:0] coef_vec_t;

    // Filter order inside a coefficient vector and inside a packed tap set.
    typedef enum logic [1:0] {
        FLT_LO_A = 2'd0,
        FLT_HI_A = 2'd1,
        FLT_LO_B = 2'd2,
        FLT_HI_B = 2'd3
    } flt_e;
endpackage

// File: rtl/dtw_tapline.sv
module dtw_tapline
    import dtw_pkg::*;
#(
    parameter int unsigned NTAP = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                push,
    input  sample_t             din,
    output sample_t [NTAP-1:0]  win,
    output logic                emit
);
    localparam int unsigned HIST = NTAP - 1;

    typedef struct packed {
        sample_t [HIST-1:0] line;   // index 0 holds the newest stored sample
        logic               odd;    // next accepted sample has an odd number
    } hist_t;

    hist_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (push) begin
            s_d.line = {s_q.line[HIST-2:0], din};
            s_d.odd  = !s_q.odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign win  = {s_q.line, din};
    assign emit = push && !clr && !s_q.odd;

    AST_CLEAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q == '0));                                    // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !clr) |=> $stable(s_q));                       // R8
endmodule

// File: rtl/dtw_fir_bank.sv
module dtw_fir_bank
    import dtw_pkg::*;
#(
    parameter int unsigned NTAP   = 10,
    parameter int unsigned COEF_W = 16,
    parameter int unsigned FRAC   = 14,
    parameter logic [NFILT*NTAP*COEF_W-1:0] TAPS_FIRST = '0,
    parameter logic [NFILT*NTAP*COEF_W-1:0] TAPS_LATER = '0
) (
    input  sample_t [NTAP-1:0] win,
    input  logic               later,
    output coef_vec_t          res
);
    localparam int unsigned PROD_W = SMP_W + COEF_W;
    localparam int unsigned ACC_W  = PROD_W + $clog2(NTAP);
    localparam int unsigned RND_W  = ACC_W + 1;
    localparam logic signed [RND_W-1:0] HALF_LSB = RND_W'(1) << (FRAC - 1);
    localparam logic signed [RND_W-1:0] SAT_HI   = RND_W'((1 << (SMP_W - 1)) - 1);
    localparam logic signed [RND_W-1:0] SAT_LO   = ~SAT_HI;

    for (genvar f = 0; f < NFILT; f++) begin : g_filt
        sample_t res_f;

        always_comb begin : mac
            logic signed [COEF_W-1:0] tap_v;
            logic signed [PROD_W-1:0] prod_v;
            logic signed [ACC_W-1:0]  acc_v;
            logic signed [RND_W-1:0]  rnd_v;
            acc_v = '0;
            for (int i = 0; i < NTAP; i++) begin
                tap_v  = later ? TAPS_LATER[(f*NTAP+i)*COEF_W +: COEF_W]
                               : TAPS_FIRST[(f*NTAP+i)*COEF_W +: COEF_W];
                prod_v = win[i] * tap_v;
                acc_v  = acc_v + ACC_W'(prod_v);
            end
            rnd_v = RND_W'(acc_v) + HALF_LSB;
            rnd_v = rnd_v >>> FRAC;
            if (rnd_v > SAT_HI)      res_f = SAT_HI[SMP_W-1:0];
            else if (rnd_v < SAT_LO) res_f = SAT_LO[SMP_W-1:0];
            else                     res_f = rnd_v[SMP_W-1:0];
        end

        assign res[f] = res_f;
    end
endmodule

// File: rtl/dtw_analysis_stage.sv
module dtw_analysis_stage
    import dtw_pkg::*;
#(
    parameter int unsigned NTAP   = 10,
    parameter int unsigned COEF_W = 16,
    parameter int unsigned FRAC   = 14,
    parameter logic [NFILT*NTAP*COEF_W-1:0] TAPS_FIRST =
        {(NFILT*NTAP){COEF_W'(1 << (FRAC - 3))}},
    parameter logic [NFILT*NTAP*COEF_W-1:0] TAPS_LATER =
        {(NFILT*NTAP){COEF_W'(1 << (FRAC - 4))}}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_data,
    input  logic                    stage_later,
    output logic signed [SMP_W-1:0] lo_a,
    output logic                    lo_a_vld,
    output logic signed [SMP_W-1:0] hi_a,
    output logic                    hi_a_vld,
    output logic signed [SMP_W-1:0] lo_b,
    output logic                    lo_b_vld,
    output logic signed [SMP_W-1:0] hi_b,
    output logic                    hi_b_vld
);
    typedef struct packed {
        logic      vld;
        coef_vec_t coef;
    } out_t;

    sample_t [NTAP-1:0] win;
    logic               emit;
    coef_vec_t          res;
    out_t               s_d, s_q;

    dtw_tapline #(.NTAP(NTAP)) u_tapline (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (in_valid),
        .din   (in_data),
        .win   (win),
        .emit  (emit)
    );

    dtw_fir_bank #(
        .NTAP       (NTAP),
        .COEF_W     (COEF_W),
        .FRAC       (FRAC),
        .TAPS_FIRST (TAPS_FIRST),
        .TAPS_LATER (TAPS_LATER)
    ) u_bank (
        .win   (win),
        .later (stage_later),
        .res   (res)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = emit;
        if (emit) s_d.coef = res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lo_a     = s_q.coef[FLT_LO_A];
    assign hi_a     = s_q.coef[FLT_HI_A];
    assign lo_b     = s_q.coef[FLT_LO_B];
    assign hi_b     = s_q.coef[FLT_HI_B];
    assign lo_a_vld = s_q.vld;
    assign hi_a_vld = s_q.vld;
    assign lo_b_vld = s_q.vld;
    assign hi_b_vld = s_q.vld;

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        lo_a_vld |=> !lo_a_vld);                                  // R3
    AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        hi_a_vld |-> $past(in_valid));                            // R3
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_b_vld |-> $stable(lo_b));                             // R3
    AST_QUIET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hi_b_vld);                                       // R7
endmodule

// File: tb/tb_dtw_analysis_stage.sv
`timescale 1ns/1ps
module tb_dtw_analysis_stage;
    localparam int NT   = 10;
    localparam int CW   = 16;
    localparam int FRC  = 14;

    function automatic int tapv(int f, int i, int s);
        if (f == 3 && s == 1) return 32767;              // all-positive set, drives saturation
        return (((f * 37 + i * 53 + s * 19 + 7) % 200) - 100) * 97;
    endfunction

    function automatic logic [4*NT*CW-1:0] pack_taps(int s);
        logic [4*NT*CW-1:0] r;
        r = '0;
        for (int f = 0; f < 4; f++)
            for (int i = 0; i < NT; i++)
                r[(f*NT+i)*CW +: CW] = CW'(tapv(f, i, s));
        return r;
    endfunction

    localparam logic [4*NT*CW-1:0] TB_FIRST = pack_taps(0);
    localparam logic [4*NT*CW-1:0] TB_LATER = pack_taps(1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic stage_later = 1'b0;
    logic signed [15:0] lo_a, hi_a, lo_b, hi_b;
    logic lo_a_vld, hi_a_vld, lo_b_vld, hi_b_vld;

    always #2 clk = ~clk;

    dtw_analysis_stage #(
        .NTAP(NT), .COEF_W(CW), .FRAC(FRC),
        .TAPS_FIRST(TB_FIRST), .TAPS_LATER(TB_LATER)
    ) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .stage_later(stage_later),
        .lo_a(lo_a), .lo_a_vld(lo_a_vld), .hi_a(hi_a), .hi_a_vld(hi_a_vld),
        .lo_b(lo_b), .lo_b_vld(lo_b_vld), .hi_b(hi_b), .hi_b_vld(hi_b_vld)
    );

    int checks = 0;
    int errors = 0;
    int out_words = 0;
    string cur_tag = "R2";

    logic signed [15:0] hist [NT];
    int phase = 0;
    logic [63:0] exp_q [$];

    function automatic logic signed [15:0] model(int f, int s);
        longint acc = 0;
        for (int i = 0; i < NT; i++) acc += longint'(hist[i]) * tapv(f, i, s);
        acc = (acc + (longint'(1) <<< (FRC - 1))) >>> FRC;
        if (acc > 32767)  return 16'sh7fff;
        if (acc < -32768) return 16'sh8000;
        return 16'(acc);
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NT; i++) hist[i] = '0;
        phase = 0;
    endtask

    task automatic send(logic signed [15:0] x, logic s);
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b1; in_data = x; stage_later = s;
        for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        if (phase == 0)
            exp_q.push_back({model(3, s), model(2, s), model(1, s), model(0, s)});
        phase ^= 1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            clr = 1'b0; in_valid = 1'b0; stage_later = ~stage_later;
        end
    endtask

    task automatic do_clear(logic with_sample);
        @(negedge clk);
        clr = 1'b1; in_valid = with_sample; in_data = 16'sd12345;
        model_clear();
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (lo_a_vld || hi_a_vld || lo_b_vld || hi_b_vld)) begin
            logic [63:0] e;
            chk("R4", "strobes aligned", {lo_a_vld, hi_a_vld, lo_b_vld, hi_b_vld}, 4'hf);
            out_words += 4;
            if (exp_q.size() == 0) begin
                chk("R3 R7", "unexpected output strobe", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(cur_tag, "lo_a", lo_a, $signed(e[15:0]));
                chk(cur_tag, "hi_a", hi_a, $signed(e[31:16]));
                chk(cur_tag, "lo_b", lo_b, $signed(e[47:32]));
                chk(cur_tag, "hi_b", hi_b, $signed(e[63:48]));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int snap;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "valid in reset", {lo_a_vld, hi_a_vld, lo_b_vld, hi_b_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", {lo_a_vld, hi_a_vld, lo_b_vld, hi_b_vld}, 0);
        chk("R1", "data after reset", {lo_a, hi_a, lo_b, hi_b}, 0);

        // R2: continuous ramp on first-level taps
        cur_tag = "R2";
        for (int k = 0; k < 24; k++) send(16'(k * 1111 - 9000), 1'b0);

        // R8: gaps between samples, later-level taps
        cur_tag = "R8";
        for (int k = 0; k < 20; k++) begin
            send(16'($urandom_range(0, 40000) - 20000), 1'b1);
            idle(k % 3);
        end

        // R5: tap set changes per sample
        cur_tag = "R5";
        for (int k = 0; k < 24; k++) send(16'($urandom_range(0, 60000) - 30000), k[0] ^ k[2]);

        // R6: saturation at both limits, then rounding on small inputs
        cur_tag = "R6";
        for (int k = 0; k < 12; k++) send(16'sd30000, 1'b1);
        for (int k = 0; k < 12; k++) send(-16'sd30000, 1'b1);
        for (int k = 0; k < 16; k++) send(16'(k % 5 - 2), k[1]);

        // R7: clear after an odd count, with and without a sample in the clear cycle
        cur_tag = "R7";
        for (int k = 0; k < 3; k++) send(16'(k * 700 + 5), 1'b0);
        do_clear(1'b1);
        for (int k = 0; k < 7; k++) send(16'(2000 - k * 333), 1'b0);
        do_clear(1'b0);
        idle(2);

        // R9: coefficient count after a clear
        cur_tag = "R9";
        do_clear(1'b0);
        idle(1);
        snap = out_words;
        for (int k = 0; k < 40; k++) send(16'(k * 523 - 10000), k[3]);
        idle(4);
        chk("R9", "coefficients for 40 samples", out_words - snap, 80);
        chk("R3", "expected results left unmatched", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule